// File: doc/BRIEF.md
# Low DRAM Region Address Decoder

This block keeps a lockable 8-bit register that records where usable low memory ends, and uses it to sort every 32-bit host address into one of four targets. The upper five register bits give address bits 31:27 of the first byte above usable memory. The lower 27 bits of that boundary are taken as zero. Any address at or above the boundary is left for other decoders, such as PCI.

Two optional regions are carved downward from the boundary. The graphics stolen region is 1 to 64 MB and sits directly below the boundary. The TSEG region is 1, 2 or 8 MB and sits directly below the graphics region. Each region's base comes from subtracting its size from the region above it. A disabled region takes no space. Configuration software writes the register through a simple write port. A lock input freezes the register until the next reset. The address classification is purely combinational.

Top module: `lowdram_decoder`

## Requirements
- R1: After a synchronous reset, `cfg_rdata` reads 08h (boundary field 1, which is 128 MB) and the register is unlocked.
- R2: Read bits 2:0 always return zero, whatever value was written to them.
- R3: While the register is unlocked, a write with a nonzero value in `cfg_wdata[7:3]` loads that field. The new value is visible on `cfg_rdata` and in the decode from the cycle after the write edge.
- R4: A write whose bits 7:3 are zero is ignored, and the previous field value is kept.
- R5: A high `lock_in` on any clock edge latches a lock that lasts until reset. A write in that same cycle, or in any later cycle, leaves the field unchanged.
- R6: An address at or above the boundary (field << 27) is classified as not-DRAM, code 3.
- R7: When `gfx_en` is high, the graphics size is (`gfx_size_code`+1) MB. An address at or above the graphics base (boundary minus that size) and below the boundary is classified as graphics, code 1.
- R8: When `tseg_en` is high, the TSEG size is selected by `tseg_size_sel`: 00 selects 1 MB, 01 selects 2 MB, and 1x selects 8 MB. An address at or above the TSEG base (graphics base minus that size) and below the graphics base is classified as TSEG, code 2.
- R9: A disabled region has size zero. Any other address below the boundary is classified as plain DRAM, code 0. With both regions disabled, every address below the boundary is DRAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| lock_in | input | 1 | Lock request, latched until reset |
| gfx_en | input | 1 | Graphics stolen region enable |
| gfx_size_code | input | 6 | Graphics size in MB minus one |
| tseg_en | input | 1 | TSEG region enable |
| tseg_size_sel | input | 2 | TSEG size select |
| host_addr | input | 32 | Address to classify |
| region | output | 2 | 0 DRAM, 1 graphics, 2 TSEG, 3 not DRAM |

## Verification
The bench sweeps all 31 legal boundary values, several graphics sizes, every TSEG select and all four enable combinations. For each setting it probes both sides of each base and of the boundary.

- An off-by-one in a compare would misclassify the probe exactly on a base or on the boundary.
- A base derived from the boundary instead of from the graphics base would put TSEG over the graphics region.
- A disabled region that still takes space would turn plain DRAM addresses into graphics or TSEG.
- A write path that accepts a zero field would collapse all of DRAM.
- A lock that is not sticky, or that loses to a write in its own cycle, would let the field change after it is locked.

// File: rtl/lowdram_pkg.sv
package lowdram_pkg;

    localparam int ADDR_W     = 32;
    localparam int REG_W      = 8;
    localparam int FIELD_W    = 5;
    localparam int BOUND_LSB  = ADDR_W - FIELD_W;
    localparam int RSVD_W     = REG_W - FIELD_W;
    localparam int MB_SHIFT   = 20;
    localparam int GFX_CODE_W = 6;
    localparam int TSEG_SEL_W = 2;
    localparam logic [FIELD_W-1:0] FIELD_RESET = FIELD_W'(1);

    typedef enum logic [1:0] {
        RGN_DRAM = 2'd0,
        RGN_GFX  = 2'd1,
        RGN_TSEG = 2'd2,
        RGN_NONE = 2'd3
    } region_e;

    typedef struct packed {
        logic [ADDR_W-1:0] top;
        logic [ADDR_W-1:0] gfx_base;
        logic [ADDR_W-1:0] tseg_base;
    } bounds_t;

    function automatic logic [ADDR_W-1:0] field_to_addr(input logic [FIELD_W-1:0] f);
        return {f, {BOUND_LSB{1'b0}}};
    endfunction

    function automatic logic [ADDR_W-1:0] gfx_bytes(input logic en,
                                                    input logic [GFX_CODE_W-1:0] code);
        logic [ADDR_W-1:0] mb;
        mb = ADDR_W'(code) + ADDR_W'(1);
        return en ? (mb << MB_SHIFT) : '0;
    endfunction

    function automatic logic [ADDR_W-1:0] tseg_bytes(input logic en,
                                                     input logic [TSEG_SEL_W-1:0] sel);
        logic [ADDR_W-1:0] mb;
        case (sel)
            2'b00:   mb = ADDR_W'(1);
            2'b01:   mb = ADDR_W'(2);
            default: mb = ADDR_W'(8);
        endcase
        return en ? (mb << MB_SHIFT) : '0;
    endfunction

endpackage

// File: rtl/lowdram_topreg.sv
module lowdram_topreg
    import lowdram_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic [REG_W-1:0]   wdata,
    input  logic               lock_req,
    output logic [FIELD_W-1:0] field,
    output logic [REG_W-1:0]   rdata
);

    logic               lock_q;
    logic [FIELD_W-1:0] field_q;
    logic [FIELD_W-1:0] new_field;
    logic               locked_now;
    logic               accept;

    assign new_field  = wdata[REG_W-1:RSVD_W];
    assign locked_now = lock_q | lock_req;
    assign accept     = wr & ~locked_now & (new_field != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q  <= 1'b0;
            field_q <= FIELD_RESET;
        end else begin
            if (lock_req)
                lock_q <= 1'b1;
            if (accept)
                field_q <= new_field;
        end
    end

    assign field = field_q;
    assign rdata = {field_q, {RSVD_W{1'b0}}};

    AST_FIELD_NONZERO: assert property (@(posedge clk) disable iff (rst)
        field_q != '0) else $error("field zero"); // R4
    AST_ZERO_WRITE_KEPT: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata[REG_W-1:RSVD_W] == '0) |=> $stable(field_q)) else $error("zero write taken"); // R4
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> lock_q) else $error("lock dropped"); // R5
    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (lock_q || lock_req) |=> $stable(field_q)) else $error("locked field moved"); // R5

endmodule

// File: rtl/lowdram_bases.sv
module lowdram_bases
    import lowdram_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [FIELD_W-1:0]    field,
    input  logic                  gfx_en,
    input  logic [GFX_CODE_W-1:0] gfx_code,
    input  logic                  tseg_en,
    input  logic [TSEG_SEL_W-1:0] tseg_sel,
    output bounds_t               bnd
);

    logic [ADDR_W-1:0] gsize;
    logic [ADDR_W-1:0] tsize;

    always_comb begin
        gsize         = gfx_bytes(gfx_en, gfx_code);
        tsize         = tseg_bytes(tseg_en, tseg_sel);
        bnd.top       = field_to_addr(field);
        bnd.gfx_base  = bnd.top - gsize;
        bnd.tseg_base = bnd.gfx_base - tsize;
    end

    AST_BASE_ORDER: assert property (@(posedge clk) disable iff (rst)
        (bnd.tseg_base <= bnd.gfx_base) && (bnd.gfx_base <= bnd.top)) else $error("bases out of order"); // R8
    AST_GFX_OFF: assert property (@(posedge clk) disable iff (rst)
        !gfx_en |-> bnd.gfx_base == bnd.top) else $error("disabled gfx takes space"); // R9
    AST_TSEG_OFF: assert property (@(posedge clk) disable iff (rst)
        !tseg_en |-> bnd.tseg_base == bnd.gfx_base) else $error("disabled tseg takes space"); // R9

endmodule

// File: rtl/lowdram_classify.sv
module lowdram_classify
    import lowdram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bounds_t           bnd,
    input  logic [ADDR_W-1:0] addr,
    output region_e           rgn
);

    logic below_top;
    logic in_gfx;
    logic in_tseg;

    assign below_top = addr < bnd.top;
    assign in_gfx    = addr >= bnd.gfx_base;
    assign in_tseg   = addr >= bnd.tseg_base;

    always_comb begin
        if (!below_top)
            rgn = RGN_NONE;
        else if (in_gfx)
            rgn = RGN_GFX;
        else if (in_tseg)
            rgn = RGN_TSEG;
        else
            rgn = RGN_DRAM;
    end

    AST_ABOVE_NONE: assert property (@(posedge clk) disable iff (rst)
        (addr >= bnd.top) |-> rgn == RGN_NONE) else $error("above top claimed"); // R6
    AST_LOW_DRAM: assert property (@(posedge clk) disable iff (rst)
        (addr < bnd.tseg_base) |-> rgn == RGN_DRAM) else $error("low addr not dram"); // R9

endmodule

// File: rtl/lowdram_decoder.sv
module lowdram_decoder
    import lowdram_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_wr,
    input  logic [REG_W-1:0]      cfg_wdata,
    output logic [REG_W-1:0]      cfg_rdata,
    input  logic                  lock_in,
    input  logic                  gfx_en,
    input  logic [GFX_CODE_W-1:0] gfx_size_code,
    input  logic                  tseg_en,
    input  logic [TSEG_SEL_W-1:0] tseg_size_sel,
    input  logic [ADDR_W-1:0]     host_addr,
    output logic [1:0]            region
);

    logic [FIELD_W-1:0] field;
    bounds_t            bnd;
    region_e            rgn;

    lowdram_topreg u_reg (
        .clk      (clk),
        .rst      (rst),
        .wr       (cfg_wr),
        .wdata    (cfg_wdata),
        .lock_req (lock_in),
        .field    (field),
        .rdata    (cfg_rdata)
    );

    lowdram_bases u_bases (
        .clk      (clk),
        .rst      (rst),
        .field    (field),
        .gfx_en   (gfx_en),
        .gfx_code (gfx_size_code),
        .tseg_en  (tseg_en),
        .tseg_sel (tseg_size_sel),
        .bnd      (bnd)
    );

    lowdram_classify u_cls (
        .clk  (clk),
        .rst  (rst),
        .bnd  (bnd),
        .addr (host_addr),
        .rgn  (rgn)
    );

    assign region = rgn;

    AST_GFX_ONLY_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (region == 2'd1) |-> gfx_en) else $error("gfx hit while disabled"); // R7
    AST_TSEG_ONLY_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (region == 2'd2) |-> tseg_en) else $error("tseg hit while disabled"); // R8

endmodule

// File: tb/lowdram_decoder_bench.sv
module lowdram_decoder_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        lock_in = 1'b0;
    logic        gfx_en = 1'b0;
    logic [5:0]  gfx_size_code = 6'd0;
    logic        tseg_en = 1'b0;
    logic [1:0]  tseg_size_sel = 2'd0;
    logic [31:0] host_addr = 32'd0;
    logic [1:0]  region;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    lowdram_decoder u_lowdram_decoder (
        .clk           (clk),
        .rst           (rst),
        .cfg_wr        (cfg_wr),
        .cfg_wdata     (cfg_wdata),
        .cfg_rdata     (cfg_rdata),
        .lock_in       (lock_in),
        .gfx_en        (gfx_en),
        .gfx_size_code (gfx_size_code),
        .tseg_en       (tseg_en),
        .tseg_size_sel (tseg_size_sel),
        .host_addr     (host_addr),
        .region        (region)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] d, input logic lk);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_wdata = d;
        lock_in   = lk;
        @(negedge clk);
        cfg_wr    = 1'b0;
        lock_in   = 1'b0;
    endtask

    function automatic logic [1:0] model(input logic [4:0] f, input logic ge,
                                         input logic [5:0] gc, input logic te,
                                         input logic [1:0] ts, input logic [31:0] a);
        logic [31:0] top, gs, tsz, gb, tb;
        top = {f, 27'd0};
        gs  = ge ? ((32'(gc) + 32'd1) << 20) : 32'd0;
        tsz = te ? ((ts == 2'b00 ? 32'd1 : ts == 2'b01 ? 32'd2 : 32'd8) << 20) : 32'd0;
        gb  = top - gs;
        tb  = gb - tsz;
        if (a >= top) return 2'd3;
        if (a >= gb)  return 2'd1;
        if (a >= tb)  return 2'd2;
        return 2'd0;
    endfunction

    task automatic probe(input logic [4:0] f, input logic [31:0] a);
        logic [1:0] e;
        host_addr = a;
        #1;
        e = model(f, gfx_en, gfx_size_code, tseg_en, tseg_size_sel, a);
        case (e)
            2'd3:    chk("R6 not-dram", 32'(region), 32'(e));
            2'd1:    chk("R7 gfx", 32'(region), 32'(e));
            2'd2:    chk("R8 tseg", 32'(region), 32'(e));
            default: chk("R9 dram", 32'(region), 32'(e));
        endcase
    endtask

    task automatic sweep(input logic [4:0] f);
        logic [5:0]  codes [3];
        logic [31:0] top, gb, tb;
        codes[0] = 6'd0; codes[1] = 6'd7; codes[2] = 6'd63;
        for (int ci = 0; ci < 3; ci++) begin
            for (int ts = 0; ts < 4; ts++) begin
                for (int en = 0; en < 4; en++) begin
                    gfx_size_code = codes[ci];
                    tseg_size_sel = 2'(ts);
                    gfx_en        = en[0];
                    tseg_en       = en[1];
                    top = {f, 27'd0};
                    gb  = top - (gfx_en ? ((32'(codes[ci]) + 32'd1) << 20) : 32'd0);
                    tb  = gb - (tseg_en ? ((ts == 0 ? 32'd1 : ts == 1 ? 32'd2 : 32'd8) << 20) : 32'd0);
                    probe(f, 32'd0);
                    probe(f, top - 32'd1);
                    probe(f, top);
                    probe(f, 32'hFFFF_FFFF);
                    probe(f, gb);
                    probe(f, gb - 32'd1);
                    probe(f, tb);
                    probe(f, tb - 32'd1);
                end
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset value", 32'(cfg_rdata), 32'h08);

        // R1: reset field 1 means the boundary is 128 MB
        probe(5'd1, 32'h07FF_FFFF);
        probe(5'd1, 32'h0800_0000);

        wr_reg(8'hFF, 1'b0);
        chk("R2 reserved bits read zero", 32'(cfg_rdata[2:0]), 32'h0);
        chk("R3 write 0xFF", 32'(cfg_rdata), 32'hF8);

        wr_reg(8'h07, 1'b0);
        chk("R4 zero field ignored", 32'(cfg_rdata), 32'hF8);

        wr_reg(8'h0D, 1'b0);
        chk("R2 reserved masked", 32'(cfg_rdata), 32'h08);

        for (int f = 1; f < 32; f++) begin
            wr_reg({5'(f), 3'b101}, 1'b0);
            chk("R3 field load", 32'(cfg_rdata), 32'({5'(f), 3'b000}));
            sweep(5'(f));
        end

        // R5: lock in the same cycle as a write blocks that write
        wr_reg(8'h10, 1'b0);
        chk("R3 pre-lock", 32'(cfg_rdata), 32'h10);
        wr_reg(8'h48, 1'b1);
        chk("R5 write with lock blocked", 32'(cfg_rdata), 32'h10);
        wr_reg(8'h88, 1'b0);
        chk("R5 lock sticky", 32'(cfg_rdata), 32'h10);
        gfx_en = 1'b0; tseg_en = 1'b0;
        probe(5'd2, 32'h0FFF_FFFF);
        probe(5'd2, 32'h1000_0000);

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset after lock", 32'(cfg_rdata), 32'h08);
        wr_reg(8'h20, 1'b0);
        chk("R1 unlocked after reset", 32'(cfg_rdata), 32'h20);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule